// File: doc/BRIEF.md
# SD Card Start-Up Command Sequencer

This block brings an SD card from power-on to the ready state in native bus mode. It runs on the slow identification clock (nominally 400 kHz), and every count it keeps is in cycles of that clock. After reset it holds the command interface quiet for a run of idle clocks. It then issues the reset command (index 0), which expects no response. Next comes the interface-condition check (index 8), whose response must return the argument unchanged. Last, it repeats the operating-condition query (index 55 with a zero argument, then index 41) until the card reports that power-up is complete.

The sequencer does not serialise anything. It presents an index, a 32-bit argument and an expect-response flag, and it pulses a start strobe for one cycle. A separate command framer sends the command and returns a done strobe with the parsed response index, the 32-bit argument, and a flag that covers both timeout and CRC failure. The sequencer inspects the status bits in each response. It retries an application-command prefix that reports a CRC error on the previous command. It also enforces a minimum quiet gap between the end of one exchange and the start of the next. The result is shown by three flags (busy, ready, error) and an error code that explains any failure.

Top module: `sd_init_seq`

## Requirements
- R1: After reset is released, at least IDLE_CYC full cycles pass before the first start pulse. The first command is index 0 with argument 0 and expect-response low.
- R2: The second command is index 8 with argument 0x000001AA and expect-response high.
- R3: A response with the fail flag set ends the sequence with error code 1. This applies to index 8, 55 or 41. A response to index 8 or 55 whose index field differs from the command's index also ends with code 1.
- R4: An index 8 response whose argument is not exactly 0x000001AA (for example, a wrong low check byte) ends the sequence with error code 2.
- R5: Every index 41 command is sent directly after an accepted index 55 command with argument 0. Index 41 carries argument OCR_ARG, and both commands set expect-response.
- R6: If an index 55 response has bit 23 set, index 55 is sent again. After APP_RETRY consecutive resends, one more response with bit 23 set ends the sequence with error code 3.
- R7: If an index 55 response has bit 23 clear but bit 5 (application mode) clear, the sequence ends with error code 5.
- R8: If an index 41 response has bit 31 set, the sequence ends with ready. If bit 31 is clear, the sequence loops to index 55. The OCR_TRIES-th clear response ends the sequence with error code 4.
- R9: Between the cycle in which rsp_done is high and the next start pulse, at least GAP_CYC cycles pass.
- R10: The start signal is a single-cycle pulse that occurs only while busy is high. Exactly one of busy, ready and error is high at all times. After ready or error, no command is issued and the flags and code hold until reset.
- R11: During reset, busy is 1, and ready, error, err_code and cmd_start are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Identification-rate clock |
| rst | input | 1 | Synchronous active-high reset; the sequence starts when it is released |
| cmd_start | output | 1 | One-cycle strobe that issues a command to the framer |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_rsp_exp | output | 1 | High when the command expects a response |
| rsp_done | input | 1 | Framer strobe marking the end of an exchange |
| rsp_fail | input | 1 | Response timed out or failed its CRC |
| rsp_idx | input | 6 | Index field of the received response |
| rsp_arg | input | 32 | Argument or status field of the received response |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | Card reported power-up complete |
| error | output | 1 | Sequence stopped on a fault |
| err_code | output | 3 | 0 none, 1 no/bad response, 2 echo mismatch, 3 CRC retries used up, 4 power-up timeout, 5 application mode missing |

## Verification
The bench goes after the retry boundaries: a single CRC-flagged prefix must be retried, while the retry that runs past the limit must fail. A design with an off-by-one error there either gives up too early or loops one time too many. The bench drives a card that stays busy for exactly OCR_TRIES queries, so a miscounted loop reports ready or keeps issuing commands. It also feeds a wrong check byte and missing responses, and a design that skipped those checks would go on to index 55. The monitor measures every inter-command gap and the idle run after reset, which catches a gap timer that is loaded late or reloaded short.

// File: rtl/sdi_pkg.sv
package sdi_pkg;
  typedef enum logic [1:0] {STEP_GO, STEP_IF, STEP_APP, STEP_OP} step_t;

  localparam logic [2:0] E_NONE    = 3'd0;
  localparam logic [2:0] E_NORSP   = 3'd1;
  localparam logic [2:0] E_ECHO    = 3'd2;
  localparam logic [2:0] E_APPCRC  = 3'd3;
  localparam logic [2:0] E_PWRTIME = 3'd4;
  localparam logic [2:0] E_NOAPP   = 3'd5;

  localparam logic [5:0]  IX_GO  = 6'd0;
  localparam logic [5:0]  IX_IF  = 6'd8;
  localparam logic [5:0]  IX_APP = 6'd55;
  localparam logic [5:0]  IX_OP  = 6'd41;
  localparam logic [31:0] IF_ARG = 32'h0000_01AA;

  localparam int B_CRCERR = 23;
  localparam int B_APPMOD = 5;
  localparam int B_PWRUP  = 31;
endpackage

// File: rtl/sdi_timer.sv
module sdi_timer #(
  parameter int W    = 8,
  parameter int INIT = 74
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= W'(INIT);
    else if (load)        cnt <= val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R9
  hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (zero && !load) |=> zero);
endmodule

// File: rtl/sdi_tally.sv
module sdi_tally #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int W = $clog2(LIMIT + 2);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)                cnt <= '0;
    else if (inc && !hit)          cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == W'(LIMIT));

  // R6
  no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && !clr) |=> hit);
endmodule

// File: rtl/sdi_rsp_eval.sv
module sdi_rsp_eval
  import sdi_pkg::*;
(
  input  step_t       step,
  input  logic        fail,
  input  logic [5:0]  idx,
  input  logic [31:0] arg,
  input  logic        crc_hit,
  input  logic        op_hit,
  output step_t       nstep,
  output logic        fin_ok,
  output logic        fin_err,
  output logic [2:0]  code,
  output logic        crc_inc,
  output logic        crc_clr,
  output logic        op_inc
);
  always_comb begin
    nstep   = step;
    fin_ok  = 1'b0;
    fin_err = 1'b0;
    code    = E_NONE;
    crc_inc = 1'b0;
    crc_clr = 1'b0;
    op_inc  = 1'b0;
    case (step)
      STEP_GO: nstep = STEP_IF;
      STEP_IF: begin
        if (fail || idx != IX_IF) begin fin_err = 1'b1; code = E_NORSP; end
        else if (arg != IF_ARG)   begin fin_err = 1'b1; code = E_ECHO;  end
        else                      nstep = STEP_APP;
      end
      STEP_APP: begin
        if (fail || idx != IX_APP) begin fin_err = 1'b1; code = E_NORSP; end
        else if (arg[B_CRCERR]) begin
          if (crc_hit) begin fin_err = 1'b1; code = E_APPCRC; end
          else           crc_inc = 1'b1;
        end
        else if (!arg[B_APPMOD]) begin fin_err = 1'b1; code = E_NOAPP; end
        else begin crc_clr = 1'b1; nstep = STEP_OP; end
      end
      default: begin
        if (fail)                begin fin_err = 1'b1; code = E_NORSP; end
        else if (arg[B_PWRUP])   fin_ok = 1'b1;
        else if (op_hit)         begin fin_err = 1'b1; code = E_PWRTIME; end
        else begin op_inc = 1'b1; nstep = STEP_APP; end
      end
    endcase
  end
endmodule

// File: rtl/sd_init_seq.sv
module sd_init_seq
  import sdi_pkg::*;
#(
  parameter int          IDLE_CYC  = 74,
  parameter int          GAP_CYC   = 8,
  parameter int          APP_RETRY = 2,
  parameter int          OCR_TRIES = 1000,
  parameter logic [31:0] OCR_ARG   = 32'h40FF_8000
) (
  input  logic        clk,
  input  logic        rst,
  output logic        cmd_start,
  output logic [5:0]  cmd_idx,
  output logic [31:0] cmd_arg,
  output logic        cmd_rsp_exp,
  input  logic        rsp_done,
  input  logic        rsp_fail,
  input  logic [5:0]  rsp_idx,
  input  logic [31:0] rsp_arg,
  output logic        busy,
  output logic        ready,
  output logic        error,
  output logic [2:0]  err_code
);
  localparam int TMAX = (IDLE_CYC > GAP_CYC) ? IDLE_CYC : GAP_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int MW   = $clog2(GAP_CYC + 2);

  typedef enum logic [1:0] {ST_WAIT, ST_RESP, ST_HALT} st_t;
  st_t   st;
  step_t step, ev_nstep;
  logic  tmr_zero, take;
  logic  ev_ok, ev_err, ev_crc_inc, ev_crc_clr, ev_op_inc, crc_hit, op_hit;
  logic [2:0]  ev_code;
  logic [5:0]  nx_idx;
  logic [31:0] nx_arg;

  assign take = (st == ST_RESP) && rsp_done;

  sdi_timer #(.W(TW), .INIT(IDLE_CYC)) u_tmr (
    .clk(clk), .rst(rst), .load(take), .val(TW'(GAP_CYC)), .zero(tmr_zero));

  sdi_tally #(.LIMIT(APP_RETRY)) u_crc (
    .clk(clk), .rst(rst), .clr(take && ev_crc_clr),
    .inc(take && ev_crc_inc), .hit(crc_hit));

  sdi_tally #(.LIMIT(OCR_TRIES - 1)) u_op (
    .clk(clk), .rst(rst), .clr(1'b0),
    .inc(take && ev_op_inc), .hit(op_hit));

  sdi_rsp_eval u_eval (
    .step(step), .fail(rsp_fail), .idx(rsp_idx), .arg(rsp_arg),
    .crc_hit(crc_hit), .op_hit(op_hit), .nstep(ev_nstep),
    .fin_ok(ev_ok), .fin_err(ev_err), .code(ev_code),
    .crc_inc(ev_crc_inc), .crc_clr(ev_crc_clr), .op_inc(ev_op_inc));

  always_comb begin
    case (step)
      STEP_GO:  begin nx_idx = IX_GO;  nx_arg = '0;      end
      STEP_IF:  begin nx_idx = IX_IF;  nx_arg = IF_ARG;  end
      STEP_APP: begin nx_idx = IX_APP; nx_arg = '0;      end
      default:  begin nx_idx = IX_OP;  nx_arg = OCR_ARG; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_WAIT;
      step        <= STEP_GO;
      cmd_start   <= 1'b0;
      cmd_idx     <= '0;
      cmd_arg     <= '0;
      cmd_rsp_exp <= 1'b0;
      busy        <= 1'b1;
      ready       <= 1'b0;
      error       <= 1'b0;
      err_code    <= E_NONE;
    end else begin
      cmd_start <= 1'b0;
      case (st)
        ST_WAIT: if (tmr_zero) begin
          cmd_start   <= 1'b1;
          cmd_idx     <= nx_idx;
          cmd_arg     <= nx_arg;
          cmd_rsp_exp <= (step != STEP_GO);
          st          <= ST_RESP;
        end
        ST_RESP: if (rsp_done) begin
          if (ev_err) begin
            st <= ST_HALT; busy <= 1'b0; error <= 1'b1; err_code <= ev_code;
          end else if (ev_ok) begin
            st <= ST_HALT; busy <= 1'b0; ready <= 1'b1;
          end else begin
            step <= ev_nstep;
            st   <= ST_WAIT;
          end
        end
        default: ;
      endcase
    end
  end

  // gap monitor for the spacing check
  logic [MW-1:0] gap_mon;
  always_ff @(posedge clk) begin
    if (rst)                               gap_mon <= MW'(GAP_CYC + 1);
    else if (rsp_done)                     gap_mon <= '0;
    else if (gap_mon != MW'(GAP_CYC + 1))  gap_mon <= gap_mon + 1'b1;
  end

  // R9
  gap_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_start |-> (gap_mon > MW'(GAP_CYC)));
  // R10
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_start |=> !cmd_start);
  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_start |-> busy);
  // R10
  flags_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({busy, ready, error}) == 1);
  // R10
  error_hold_chk: assert property (@(posedge clk) disable iff (rst)
    error |=> (error && $stable(err_code)));
  // R10
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> (ready && !cmd_start));
endmodule

// File: tb/sim_sd_init_seq.sv
`timescale 1ns/1ps
module sim_sd_init_seq;
  localparam int IDLE = 74, GAP = 8, RETRY = 2, TRIES = 4, LAT = 5;
  localparam logic [31:0] OCR = 32'h40FF_8000;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_start, cmd_rsp_exp, busy, ready, error;
  logic [5:0]  cmd_idx;
  logic [31:0] cmd_arg;
  logic [2:0]  err_code;
  logic rsp_done = 1'b0, rsp_fail = 1'b0;
  logic [5:0]  rsp_idx = '0;
  logic [31:0] rsp_arg = '0;

  always #2.5 clk = ~clk;

  sd_init_seq #(.IDLE_CYC(IDLE), .GAP_CYC(GAP), .APP_RETRY(RETRY),
                .OCR_TRIES(TRIES), .OCR_ARG(OCR)) u0 (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_idx(cmd_idx),
    .cmd_arg(cmd_arg), .cmd_rsp_exp(cmd_rsp_exp), .rsp_done(rsp_done),
    .rsp_fail(rsp_fail), .rsp_idx(rsp_idx), .rsp_arg(rsp_arg),
    .busy(busy), .ready(ready), .error(error), .err_code(err_code));

  int nchk = 0, nfail = 0;
  logic [5:0]  q_idx[$];  logic [31:0] q_arg[$];  logic q_rx[$];  string q_tag[$];
  logic [5:0]  r_idx[$];  logic [31:0] r_arg[$];  logic r_fail[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic ex(input logic [5:0] idx, input logic [31:0] arg, input logic rx,
                    input logic [5:0] ridx, input logic [31:0] rarg, input logic rf,
                    input string tag);
    q_idx.push_back(idx); q_arg.push_back(arg); q_rx.push_back(rx); q_tag.push_back(tag);
    r_idx.push_back(ridx); r_arg.push_back(rarg); r_fail.push_back(rf);
  endtask

  task automatic pre();
    ex(6'd0, 32'h0, 1'b0, 6'd0, 32'h0, 1'b0, "R1");
    ex(6'd8, 32'h1AA, 1'b1, 6'd8, 32'h1AA, 1'b0, "R2");
  endtask
  task automatic app(input logic [31:0] st);
    ex(6'd55, 32'h0, 1'b1, 6'd55, st, 1'b0, "R5");
  endtask
  task automatic op(input bit done);
    ex(6'd41, OCR, 1'b1, 6'h3F, done ? 32'hC0FF_8000 : 32'h00FF_8000, 1'b0, "R5");
  endtask

  // reference monitor, compared on every clock
  int since_rst = 0, since_done = 0;
  bit first = 1'b1;
  always @(negedge clk) begin
    if (rst) begin
      since_rst = 0; since_done = 100000; first = 1'b1;
    end else begin
      since_rst++; since_done++;
      if (rsp_done) since_done = 0;
      chk((busy + ready + error) == 1, "R10", "flag exclusivity",
          {29'd0, busy, ready, error}, 32'd4);
      if (cmd_start) begin
        if (first) chk(since_rst - 1 >= IDLE, "R1", "idle run", since_rst - 1, IDLE);
        else       chk(since_done - 1 >= GAP, "R9", "command gap", since_done - 1, GAP);
        first = 1'b0;
        if (q_idx.size() == 0)
          chk(1'b0, "R10", "command after end", {26'd0, cmd_idx}, 32'hFFFF);
        else begin
          string t;
          t = q_tag.pop_front();
          chk(cmd_idx == q_idx[0], t, "index", {26'd0, cmd_idx}, {26'd0, q_idx[0]});
          chk(cmd_arg == q_arg[0], t, "argument", cmd_arg, q_arg[0]);
          chk(cmd_rsp_exp == q_rx[0], t, "expect flag", {31'd0, cmd_rsp_exp}, {31'd0, q_rx[0]});
          void'(q_idx.pop_front()); void'(q_arg.pop_front()); void'(q_rx.pop_front());
        end
      end
    end
  end

  // framer and card model
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && cmd_start && r_idx.size() > 0) begin
        logic [5:0] i; logic [31:0] a; logic f;
        i = r_idx.pop_front(); a = r_arg.pop_front(); f = r_fail.pop_front();
        repeat (LAT) @(posedge clk);
        #1; rsp_done = 1'b1; rsp_idx = i; rsp_arg = a; rsp_fail = f;
        @(posedge clk);
        #1; rsp_done = 1'b0;
      end
    end
  end

  task automatic run(input string tag, input bit want_ok, input logic [2:0] want_code);
    int n;
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(busy && !ready && !error && err_code == 0 && !cmd_start, "R11", "reset state",
        {27'd0, busy, ready, error, cmd_start, |err_code}, 32'h10);
    @(posedge clk); #1 rst = 1'b0;
    n = 0;
    while (!(ready || error) && n < 5000) begin @(negedge clk); n++; end
    repeat (40) @(negedge clk);
    chk(ready == want_ok, tag, "ready", {31'd0, ready}, {31'd0, want_ok});
    chk(error == !want_ok, tag, "error", {31'd0, error}, {31'd0, !want_ok});
    chk(err_code == want_code, tag, "error code", {29'd0, err_code}, {29'd0, want_code});
    chk(q_idx.size() == 0, tag, "commands left unissued", q_idx.size(), 0);
    q_idx.delete(); q_arg.delete(); q_rx.delete(); q_tag.delete();
    r_idx.delete(); r_arg.delete(); r_fail.delete();
  endtask

  initial begin
    // R8 nominal: one busy answer then ready
    pre(); app(32'h120); op(1'b0); app(32'h120); op(1'b1);
    run("R8", 1'b1, 3'd0);
    // R6 single CRC-flagged prefix retried
    pre(); app(32'h0080_0120); app(32'h120); op(1'b1);
    run("R6", 1'b1, 3'd0);
    // R6 retries used up
    pre(); app(32'h0080_0120); app(32'h0080_0120); app(32'h0080_0120);
    run("R6", 1'b0, 3'd3);
    // R4 wrong check byte
    ex(6'd0, 32'h0, 1'b0, 6'd0, 32'h0, 1'b0, "R1");
    ex(6'd8, 32'h1AA, 1'b1, 6'd8, 32'h155, 1'b0, "R2");
    run("R4", 1'b0, 3'd2);
    // R3 no response to index 8
    ex(6'd0, 32'h0, 1'b0, 6'd0, 32'h0, 1'b0, "R1");
    ex(6'd8, 32'h1AA, 1'b1, 6'd8, 32'h0, 1'b1, "R2");
    run("R3", 1'b0, 3'd1);
    // R8 power-up never completes
    pre();
    for (int k = 0; k < TRIES; k++) begin app(32'h120); op(1'b0); end
    run("R8", 1'b0, 3'd4);
    // R7 application mode bit missing
    pre(); app(32'h100);
    run("R7", 1'b0, 3'd5);
    // R3 failed response to index 41
    pre(); app(32'h120);
    ex(6'd41, OCR, 1'b1, 6'h3F, 32'h0, 1'b1, "R5");
    run("R3", 1'b0, 3'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #750000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule